// File: doc/BRIEF.md
# Command-word I2C master

This block is an I2C bus master that carries out one operation per 32-bit command word. Each word holds up to three data bytes. Bits 31:24 carry the first byte, bits 23:16 the second and bits 15:8 the third. The low bits of the word are control flags. They choose whether a START is generated, whether a STOP closes the command, whether two or three bytes are written, how a read byte is acknowledged, and which of two bus rates is used.

Clearing the START and STOP flags on successive commands lets software build one long transaction from several short commands. A command that skips its START reuses the direction taken from bit 24 of the last command that did send one. The block drives SCL and SDA as open-drain pull-downs and samples SDA back. It returns the last byte read in a status word, together with a busy flag and a sticky flag for a missing acknowledge, and it pulses a done strobe when each command ends.

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset both bus lines are released (scl_oe and sda_oe low), and the status word reads zero.
- R2: A command with bit 1 clear and bit 24 clear sends a START, then the bytes in bits 31:24 and 23:16 in that order, most significant bit first. The byte in bits 15:8 follows only when bit 0 is set. When bit 2 is clear the command closes with a STOP.
- R3: A command with bit 2 set ends without a STOP and leaves SCL held low. A following command with bit 1 clear produces a repeated START.
- R4: A command with bit 1 set sends no START and moves one byte. The direction is the one saved from bit 24 of the last command that sent a START. A write sends bits 31:24.
- R5: A command with bit 1 clear and bit 24 set sends the address byte and then reads one byte. The master then drives ACK (SDA low) if bit 0 is set and NACK otherwise. The byte read appears in status bits 15:8.
- R6: A chain of commands, where every command after the first has bit 1 set, forms a single transaction on the bus with exactly one START. This holds for both multi-byte writes and multi-byte reads.
- R7: If a slave does not acknowledge a written byte, status bit 1 is set, a STOP is sent even when bit 2 is set, and no further byte of that command is sent. The flag holds until the next command with bit 1 clear is accepted, which clears it.
- R8: Bit 3 selects the bus rate, SLOW_HZ when clear and FAST_HZ when set. With Q = CLK_HZ/(4·rate), rounded down, each SCL high phase of a data bit lasts exactly 2·Q clock cycles.
- R9: While SCL is released during a data or acknowledge bit, the master does not change SDA. SDA moves under a high SCL only for START and STOP.
- R10: status bit 0 is high from the cycle after a command is accepted until the command ends. done pulses for exactly one cycle at the end. A command presented while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, accepted when not busy |
| cmd_word | input | 32 | Command: data bytes in 31:8, flags in 3:0 |
| done | output | 1 | One-cycle pulse at the end of a command |
| status | output | 32 | [15:8] last read byte, [1] no-ack flag, [0] busy |
| scl_oe | output | 1 | Pull SCL low when high |
| sda_oe | output | 1 | Pull SDA low when high |
| sda_in | input | 1 | Sampled SDA level |

## Verification
Assertions check on every cycle that:
- SDA holds still while SCL is high inside data bits.
- Quarter ticks never come back to back at a rate above the minimum.
- A STOP is only generated when the command allowed it or a no-acknowledge forced it.
- The no-ack flag stays set until a START command is accepted.
- A command arriving while busy leaves the latched word untouched.
- done lasts exactly one cycle.

Only the bench's scenarios can show the transaction-level behaviour, using a behavioural slave on the wired bus:
- byte order and count on the wire
- one START per chained transaction, and the repeated START
- ACK and NACK choice after reads
- the returned read data
- the exact SCL high time at both rates.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    // Bit-level operations performed by the bit engine.
    typedef enum logic [1:0] {
        BOP_START = 2'd0,
        BOP_STOP  = 2'd1,
        BOP_WRITE = 2'd2,
        BOP_READ  = 2'd3
    } bop_e;

    // Command-level states of the byte sequencer.
    typedef enum logic [1:0] {
        CS_IDLE  = 2'd0,
        CS_START = 2'd1,
        CS_BITS  = 2'd2,
        CS_STOP  = 2'd3
    } cst_e;

    // Flag positions inside the command word.
    localparam int unsigned CB_W3      = 0;
    localparam int unsigned CB_NOSTART = 1;
    localparam int unsigned CB_NOSTOP  = 2;
    localparam int unsigned CB_FAST    = 3;
    localparam int unsigned CB_DIR     = 24;

    // Status word field positions.
    localparam int unsigned SB_BUSY = 0;
    localparam int unsigned SB_NACK = 1;

endpackage

// File: rtl/i2cm_tick.sv
module i2cm_tick #(
    parameter int unsigned CLK_HZ  = 125_000_000,
    parameter int unsigned SLOW_HZ = 99_200,
    parameter int unsigned FAST_HZ = 396_800
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fast,
    input  logic restart,
    output logic tick
);
    localparam int unsigned Q_SLOW_RAW = CLK_HZ / (4 * SLOW_HZ);
    localparam int unsigned Q_FAST_RAW = CLK_HZ / (4 * FAST_HZ);
    localparam int unsigned Q_SLOW     = (Q_SLOW_RAW == 0) ? 1 : Q_SLOW_RAW;
    localparam int unsigned Q_FAST     = (Q_FAST_RAW == 0) ? 1 : Q_FAST_RAW;
    localparam int unsigned Q_MAX      = (Q_SLOW > Q_FAST) ? Q_SLOW : Q_FAST;
    localparam int unsigned CW         = (Q_MAX < 2) ? 1 : $clog2(Q_MAX);
    localparam logic [CW-1:0] LIM_S    = CW'(Q_SLOW - 1);
    localparam logic [CW-1:0] LIM_F    = CW'(Q_FAST - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          tick;
    } tick_st_t;

    tick_st_t st_d, st_q;
    logic [CW-1:0] lim;

    always_comb begin
        lim       = fast ? LIM_F : LIM_S;
        st_d      = st_q;
        st_d.tick = 1'b0;
        if (restart) begin
            st_d.cnt = '0;
        end else if (st_q.cnt >= lim) begin
            st_d.cnt  = '0;
            st_d.tick = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick = st_q.tick;

    // R8
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.tick && lim != '0) |=> !st_q.tick);

endmodule

// File: rtl/i2cm_bit.sv
module i2cm_bit
    import i2cm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic req,
    input  bop_e op,
    input  logic wbit,
    input  logic sda_in,
    output logic scl_low,
    output logic sda_low,
    output logic done,
    output logic rbit
);
    typedef struct packed {
        logic       active;
        logic [1:0] ph;
        bop_e       op;
        logic       scl_low;
        logic       sda_low;
        logic       rbit;
        logic       done;
    } bit_st_t;

    bit_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (req && !st_q.active) begin
            // quarter 0: place SDA while SCL stays where it is
            st_d.active = 1'b1;
            st_d.ph     = 2'd0;
            st_d.op     = op;
            unique case (op)
                BOP_START: st_d.sda_low = 1'b0;
                BOP_STOP:  st_d.sda_low = 1'b1;
                BOP_WRITE: st_d.sda_low = !wbit;
                default:   st_d.sda_low = 1'b0;
            endcase
        end else if (st_q.active && tick) begin
            if (st_q.ph == 2'd3) begin
                st_d.active = 1'b0;
                st_d.done   = 1'b1;
            end else begin
                st_d.ph = st_q.ph + 2'd1;
                unique case (st_d.ph)
                    2'd1: st_d.scl_low = 1'b0;
                    2'd2: begin
                        if (st_q.op == BOP_START) st_d.sda_low = 1'b1;
                        if (st_q.op == BOP_STOP)  st_d.sda_low = 1'b0;
                    end
                    default: begin
                        if (st_q.op != BOP_STOP) st_d.scl_low = 1'b1;
                        if (st_q.op == BOP_READ) st_d.rbit    = sda_in;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.op <= BOP_START;
        end else begin
            st_q <= st_d;
        end
    end

    assign scl_low = st_q.scl_low;
    assign sda_low = st_q.sda_low;
    assign done    = st_q.done;
    assign rbit    = st_q.rbit;

    // R9
    sda_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && (st_q.op == BOP_WRITE || st_q.op == BOP_READ)
         && !st_q.scl_low && $past(!st_q.scl_low)) |-> $stable(st_q.sda_low));

    // R2
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && st_q.op == BOP_STOP && st_q.ph == 2'd3)
        |-> (!st_q.scl_low && !st_q.sda_low));

endmodule

// File: rtl/i2cm_ctrl.sv
module i2cm_ctrl
    import i2cm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic [31:0] cmd_word,
    input  logic        bdone,
    input  logic        brbit,
    output logic        breq,
    output bop_e        bop,
    output logic        bwbit,
    output logic        fast,
    output logic        busy,
    output logic        done,
    output logic        nack_err,
    output logic [7:0]  rd_byte
);
    typedef struct packed {
        cst_e        state;
        logic [31:0] word;
        logic        dir;
        logic        err;
        logic [3:0]  bitn;
        logic [1:0]  bytei;
        logic [7:0]  sh;
        logic [7:0]  rbyte;
        logic        pend;
        logic        req;
        bop_e        op;
        logic        wbit;
        logic        done;
    } ctl_st_t;

    ctl_st_t st_d, st_q;

    logic       nostart, nostop, w3, cur_rd;
    logic [1:0] last_idx;
    logic [7:0] cur_byte;
    logic [2:0] bidx;
    logic       accept_start;

    always_comb begin
        nostart  = st_q.word[CB_NOSTART];
        nostop   = st_q.word[CB_NOSTOP];
        w3       = st_q.word[CB_W3];
        cur_rd   = nostart ? st_q.dir : (st_q.dir && st_q.bytei != 2'd0);
        if (nostart)       last_idx = 2'd0;
        else if (st_q.dir) last_idx = 2'd1;
        else               last_idx = w3 ? 2'd2 : 2'd1;
        unique case (st_q.bytei)
            2'd0:    cur_byte = st_q.word[31:24];
            2'd1:    cur_byte = st_q.word[23:16];
            default: cur_byte = st_q.word[15:8];
        endcase
        bidx = 3'd7 - st_q.bitn[2:0];
        accept_start = (st_q.state == CS_IDLE) && cmd_valid && !cmd_word[CB_NOSTART];
    end

    always_comb begin
        st_d      = st_q;
        st_d.req  = 1'b0;
        st_d.done = 1'b0;
        unique case (st_q.state)
            CS_IDLE: begin
                if (cmd_valid) begin
                    st_d.word  = cmd_word;
                    st_d.pend  = 1'b0;
                    st_d.bytei = 2'd0;
                    st_d.bitn  = 4'd0;
                    if (!cmd_word[CB_NOSTART]) begin
                        st_d.err   = 1'b0;
                        st_d.dir   = cmd_word[CB_DIR];
                        st_d.state = CS_START;
                    end else begin
                        st_d.state = CS_BITS;
                    end
                end
            end
            CS_START: begin
                if (!st_q.pend) begin
                    st_d.req  = 1'b1;
                    st_d.pend = 1'b1;
                    st_d.op   = BOP_START;
                end else if (bdone) begin
                    st_d.pend  = 1'b0;
                    st_d.state = CS_BITS;
                end
            end
            CS_BITS: begin
                if (!st_q.pend) begin
                    st_d.req  = 1'b1;
                    st_d.pend = 1'b1;
                    if (st_q.bitn < 4'd8) begin
                        st_d.op   = cur_rd ? BOP_READ : BOP_WRITE;
                        st_d.wbit = cur_byte[bidx];
                    end else begin
                        // acknowledge slot: slave answers a write, master answers a read
                        st_d.op   = cur_rd ? BOP_WRITE : BOP_READ;
                        st_d.wbit = !w3;
                    end
                end else if (bdone) begin
                    st_d.pend = 1'b0;
                    if (st_q.bitn < 4'd8) begin
                        if (cur_rd) st_d.sh = {st_q.sh[6:0], brbit};
                        st_d.bitn = st_q.bitn + 4'd1;
                    end else if (!cur_rd && brbit) begin
                        st_d.err   = 1'b1;
                        st_d.state = CS_STOP;
                    end else begin
                        if (cur_rd) st_d.rbyte = st_q.sh;
                        if (st_q.bytei == last_idx) begin
                            if (nostop) begin
                                st_d.state = CS_IDLE;
                                st_d.done  = 1'b1;
                            end else begin
                                st_d.state = CS_STOP;
                            end
                        end else begin
                            st_d.bytei = st_q.bytei + 2'd1;
                            st_d.bitn  = 4'd0;
                        end
                    end
                end
            end
            default: begin
                if (!st_q.pend) begin
                    st_d.req  = 1'b1;
                    st_d.pend = 1'b1;
                    st_d.op   = BOP_STOP;
                end else if (bdone) begin
                    st_d.pend  = 1'b0;
                    st_d.state = CS_IDLE;
                    st_d.done  = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= CS_IDLE;
            st_q.op    <= BOP_START;
        end else begin
            st_q <= st_d;
        end
    end

    assign breq     = st_q.req;
    assign bop      = st_q.op;
    assign bwbit    = st_q.wbit;
    assign fast     = st_q.word[CB_FAST];
    assign busy     = (st_q.state != CS_IDLE);
    assign done     = st_q.done;
    assign nack_err = st_q.err;
    assign rd_byte  = st_q.rbyte;

    // R10
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && st_q.state != CS_IDLE) |=> $stable(st_q.word));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> !st_q.done);

    // R3
    stop_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == CS_STOP) |-> (!st_q.word[CB_NOSTOP] || st_q.err));

    // R7
    sticky_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.err && !accept_start) |=> st_q.err);

endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master
    import i2cm_pkg::*;
#(
    parameter int unsigned CLK_HZ  = 125_000_000,
    parameter int unsigned SLOW_HZ = 99_200,
    parameter int unsigned FAST_HZ = 396_800
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic [31:0] cmd_word,
    output logic        done,
    output logic [31:0] status,
    output logic        scl_oe,
    output logic        sda_oe,
    input  logic        sda_in
);
    logic       tick, breq, bwbit, bdone, brbit, fast, busy, nack_err;
    bop_e       bop;
    logic [7:0] rd_byte;

    i2cm_tick #(
        .CLK_HZ (CLK_HZ),
        .SLOW_HZ(SLOW_HZ),
        .FAST_HZ(FAST_HZ)
    ) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .fast   (fast),
        .restart(breq),
        .tick   (tick)
    );

    i2cm_bit u_bit (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .req    (breq),
        .op     (bop),
        .wbit   (bwbit),
        .sda_in (sda_in),
        .scl_low(scl_oe),
        .sda_low(sda_oe),
        .done   (bdone),
        .rbit   (brbit)
    );

    i2cm_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_valid(cmd_valid),
        .cmd_word (cmd_word),
        .bdone    (bdone),
        .brbit    (brbit),
        .breq     (breq),
        .bop      (bop),
        .bwbit    (bwbit),
        .fast     (fast),
        .busy     (busy),
        .done     (done),
        .nack_err (nack_err),
        .rd_byte  (rd_byte)
    );

    always_comb begin
        status          = '0;
        status[15:8]    = rd_byte;
        status[SB_NACK] = nack_err;
        status[SB_BUSY] = busy;
    end

endmodule

// File: tb/i2c_cmd_master_tb.sv
module i2c_cmd_master_tb;
    localparam int unsigned CLK_HZ  = 4_000_000;
    localparam int unsigned SLOW_HZ = 99_200;
    localparam int unsigned FAST_HZ = 396_800;
    localparam int QS = CLK_HZ / (4 * SLOW_HZ);
    localparam int QF = CLK_HZ / (4 * FAST_HZ);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [31:0] cmd_word = '0;
    logic        done;
    logic [31:0] status;
    logic        scl_oe, sda_oe;
    logic        s_pull = 1'b0;

    wire scl = ~scl_oe;
    wire sda = ~(sda_oe | s_pull);

    always #4ns clk = ~clk;

    i2c_cmd_master #(.CLK_HZ(CLK_HZ), .SLOW_HZ(SLOW_HZ), .FAST_HZ(FAST_HZ)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .done(done), .status(status), .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda)
    );

    int total = 0;
    int bad = 0;
    bit fin = 0;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- bus monitor and slave model ----------------
    logic [7:0] wr_log [64];
    logic       mack_log [16];
    int  wr_n = 0, mack_n = 0, n_start = 0, n_stop = 0;
    longint cyc = 0, t_rise = 0, hi_cyc = 0;
    logic s_act = 0, s_rd = 0, s_addr = 0, s_rise = 0, s_nak = 0, s_macked = 0;
    int  s_cnt = 0;
    logic [7:0] s_sh = '0, s_tx = '0, tx_next = 8'h3C;

    always @(posedge clk) cyc++;
    always @(posedge scl) t_rise = cyc;
    always @(negedge scl) hi_cyc = cyc - t_rise;

    always @(negedge sda) if (scl === 1'b1) begin
        n_start++;
        s_act <= 1'b1; s_cnt <= 0; s_rd <= 1'b0; s_addr <= 1'b1; s_rise <= 1'b0; s_pull <= 1'b0;
    end

    always @(posedge sda) if (scl === 1'b1) begin
        n_stop++;
        s_act <= 1'b0; s_pull <= 1'b0;
    end

    always @(posedge scl) if (s_act) begin
        s_rise <= 1'b1;
        if (s_cnt < 8) begin
            if (!s_rd) s_sh <= {s_sh[6:0], sda};
        end else if (s_rd) begin
            if (mack_n < 16) mack_log[mack_n] = sda;
            mack_n++;
            s_macked <= !sda;
        end
    end

    always @(negedge scl) if (s_act && s_rise) begin
        s_rise <= 1'b0;
        if (s_cnt < 7) begin
            s_cnt <= s_cnt + 1;
            if (s_rd) s_pull <= ~s_tx[6 - s_cnt];
        end else if (s_cnt == 7) begin
            s_cnt <= 8;
            if (!s_rd) begin
                if (wr_n < 64) wr_log[wr_n] = s_sh;
                wr_n++;
                s_pull <= ~s_nak;
            end else begin
                s_pull <= 1'b0;
            end
        end else begin
            s_cnt <= 0;
            if (!s_rd) begin
                if (s_addr && s_sh[0]) begin
                    s_rd <= 1'b1; s_tx <= tx_next; s_pull <= ~tx_next[7]; tx_next = tx_next + 8'd1;
                end else begin
                    s_pull <= 1'b0;
                end
                s_addr <= 1'b0;
            end else if (s_macked) begin
                s_tx <= tx_next; s_pull <= ~tx_next[7]; tx_next = tx_next + 8'd1;
            end else begin
                s_pull <= 1'b0;
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic clear_log();
        wr_n = 0; mack_n = 0; n_start = 0; n_stop = 0;
    endtask

    task automatic issue(input logic [31:0] w);
        @(negedge clk); cmd_valid = 1'b1; cmd_word = w;
        @(negedge clk); cmd_valid = 1'b0;
    endtask

    task automatic wait_done();
        int guard = 0;
        while (!done && guard < 40000) begin @(negedge clk); guard++; end
    endtask

    task automatic run_cmd(input logic [31:0] w);
        issue(w);
        wait_done();
    endtask

    // word layout: [31:24] b0, [23:16] b1, [15:8] b2, [3] fast, [2] no-stop, [1] no-start, [0] w3
    function automatic logic [31:0] mk(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                                       input logic fs, input logic nsp, input logic nst, input logic w3);
        return {b0, b1, b2, 4'h0, fs, nsp, nst, w3};
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!fin) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1 reset state
        chk("R1", "status", status, 0);
        chk("R1", "scl", scl, 1);
        chk("R1", "sda", sda, 1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R2 / R8: sweep of write words over byte count and rate
        for (int i = 0; i < 8; i++) begin
            logic [7:0] b1, b2;
            logic w3, fs;
            b1 = 8'(i * 37 + 5);
            b2 = 8'(255 - i * 19);
            w3 = (i % 2) == 1;
            fs = ((i / 2) % 2) == 1;
            clear_log();
            run_cmd(mk(8'hAA, b1, b2, fs, 1'b0, 1'b0, w3));
            chk("R2", "bytes", wr_n, w3 ? 3 : 2);
            chk("R2", "byte0", wr_log[0], 8'hAA);
            chk("R2", "byte1", wr_log[1], b1);
            if (w3) chk("R2", "byte2", wr_log[2], b2);
            chk("R2", "starts", n_start, 1);
            chk("R2", "stops", n_stop, 1);
            chk("R8", "scl high cycles", hi_cyc, 2 * (fs ? QF : QS));
            chk("R7", "no nack", status[1], 0);
            repeat (5) @(negedge clk);
        end

        // R3 R4 R6: chained multi-byte write
        clear_log();
        run_cmd(mk(8'hAA, 8'h01, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0));
        repeat (20) @(negedge clk);
        chk("R3", "scl held low", scl, 0);
        chk("R3", "no stop yet", n_stop, 0);
        run_cmd(mk(8'h02, 8'h00, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0));
        run_cmd(mk(8'h03, 8'h00, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0));
        chk("R6", "chain bytes", wr_n, 4);
        chk("R4", "chain b2", wr_log[2], 8'h02);
        chk("R4", "chain b3", wr_log[3], 8'h03);
        chk("R6", "chain starts", n_start, 1);
        chk("R6", "chain stops", n_stop, 1);
        repeat (5) @(negedge clk);

        // R5 R6: chained three-byte read, then repeated start
        clear_log();
        tx_next = 8'h3C;
        run_cmd(mk(8'hAB, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1));
        chk("R5", "read0", status[15:8], 8'h3C);
        run_cmd(mk(8'h00, 8'h00, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1));
        chk("R5", "read1", status[15:8], 8'h3D);
        run_cmd(mk(8'h00, 8'h00, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0));
        chk("R5", "read2", status[15:8], 8'h3E);
        chk("R5", "master acks", mack_n, 3);
        chk("R5", "ack0", mack_log[0], 0);
        chk("R5", "ack1", mack_log[1], 0);
        chk("R5", "nack last", mack_log[2], 1);
        chk("R6", "read starts", n_start, 1);
        chk("R6", "read stops", n_stop, 0);
        chk("R4", "only address written", wr_n, 1);
        run_cmd(mk(8'hAA, 8'h55, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0));
        chk("R3", "repeated start", n_start, 2);
        chk("R3", "closing stop", n_stop, 1);
        chk("R3", "write after rs", wr_log[2], 8'h55);
        repeat (5) @(negedge clk);

        // R5: single read closed by STOP, several values
        for (int k = 0; k < 3; k++) begin
            logic [7:0] v;
            v = 8'(8'h81 + k * 8'h2F);
            clear_log();
            tx_next = v;
            run_cmd(mk(8'hAB, 8'h00, 8'h00, k == 1, 1'b0, 1'b0, 1'b0));
            chk("R5", "single read", status[15:8], v);
            chk("R5", "single nack", mack_log[0], 1);
            chk("R5", "single stop", n_stop, 1);
            repeat (5) @(negedge clk);
        end

        // R7: slave refuses, stop forced despite no-stop flag
        clear_log();
        s_nak = 1'b1;
        run_cmd(mk(8'hAA, 8'h11, 8'h22, 1'b1, 1'b1, 1'b0, 1'b1));
        chk("R7", "nack flag", status[1], 1);
        chk("R7", "bytes on nack", wr_n, 1);
        chk("R7", "forced stop", n_stop, 1);
        repeat (60) @(negedge clk);
        chk("R7", "sticky", status[1], 1);
        chk("R7", "bus released", scl, 1);
        s_nak = 1'b0;
        run_cmd(mk(8'hAA, 8'h11, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0));
        chk("R7", "cleared by start", status[1], 0);
        repeat (5) @(negedge clk);

        // R10: busy, single-cycle done, commands ignored while busy
        clear_log();
        issue(mk(8'hAA, 8'h77, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0));
        repeat (20) @(negedge clk);
        chk("R10", "busy", status[0], 1);
        issue(mk(8'hAA, 8'h99, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1));
        wait_done();
        chk("R10", "done seen", done, 1);
        @(negedge clk);
        chk("R10", "done one cycle", done, 0);
        chk("R10", "idle", status[0], 0);
        repeat (300) @(negedge clk);
        chk("R10", "ignored starts", n_start, 1);
        chk("R10", "ignored bytes", wr_n, 2);
        chk("R10", "first word kept", wr_log[1], 8'h77);
        chk("R9", "stop count", n_stop, 1);

        fin = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule